// File: doc/BRIEF.md
# Timer Event Status Flags

This block is the interrupt status register of a multi-channel timer. The timer core sends it single-cycle event strobes: counter update, a capture/compare event on each of four channels, commutation, and trigger. It also receives the break input level. Each event is held in a sticky flag. Software reads the flags over a simple register port and clears any flag by writing a zero to its bit. A write of one to a bit leaves that bit unchanged.

A few flags follow their own rules. An overcapture flag marks a capture that overwrote an earlier capture on its channel before software handled it. The break flag cannot be cleared while the break input is still active. Trigger events are not flagged while the slave controller runs in gated mode. An enable mask selects which of the eight event flags drive the single interrupt request output.

Top module: `tim_event_status`

## Requirements
- R1: After reset all sixteen flag bits are 0.
- R2: Flag positions: bit 0 update, bits 1 to 4 channel 1 to 4 capture/compare, bit 5 commutation, bit 6 trigger, bit 7 break, bits 9 to 12 channel 1 to 4 overcapture. A strobe sets its flag, and the flag reads back on the clock edge that follows the strobe.
- R3: A write with selIn and wrEn high clears every flag whose wrData bit is 0. A wrData bit of 1 leaves that flag as it was.
- R4: Bits 8, 13, 14 and 15 always read 0, whatever value is written to them.
- R5: If a strobe sets a flag in the same cycle that a write clears it, the flag ends up at 1.
- R6: A channel's overcapture flag is set only when that channel's capture strobe arrives, captureMode for that channel is 1, and the channel's capture/compare flag is already 1. A capture strobe in compare mode never sets overcapture.
- R7: The break flag is set in every cycle in which brkLevel is 1. A software clear of it has an effect only while brkLevel is 0.
- R8: trgEvt sets the trigger flag only when gatedMode is 0. With gatedMode at 1, the strobe is ignored.
- R9: comEvt sets the commutation flag at bit 5.
- R10: irqOut is 1 exactly when some flag among bits 0 to 7 is 1 and its irqEnable bit is also 1. Overcapture flags never drive irqOut.
- R11: rdData shows the flags while selIn is 1 and reads 0 while selIn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selIn | input | 1 | Register select |
| wrEn | input | 1 | Write enable, used only when selIn is 1 |
| wrData | input | 16 | Write data; a 0 bit clears the matching flag |
| rdData | output | 16 | Flag contents when selected, otherwise 0 |
| irqEnable | input | 8 | Interrupt enables for flag bits 0 to 7 |
| irqOut | output | 1 | Interrupt request |
| updEvt | input | 1 | Update event strobe |
| ccEvt | input | 4 | Capture/compare event strobes, one for each channel |
| captureMode | input | 4 | 1 when the channel is in input-capture mode |
| comEvt | input | 1 | Commutation event strobe |
| trgEvt | input | 1 | Trigger edge strobe |
| gatedMode | input | 1 | 1 when the slave controller is in gated mode |
| brkLevel | input | 1 | Synchronized break input level, active high |

## Verification
The bench looks for these faults. A clear that wins over a set in the same cycle would lose an event. An overcapture might be tested against the new capture instead of the flag that was already set, or might fire in compare mode. A break flag could be cleared while break is still active. A trigger could be flagged in gated mode. An overcapture flag might leak onto the interrupt line. A write of one might corrupt a flag, or a reserved bit might take a written value. Each of these faults shows up as a wrong readback value or a wrong irqOut. A long random run with a fixed seed mixes all the events with clears and enable patterns, and checks every cycle against a reference model.

// File: rtl/tes_pkg.sv
package tes_pkg;
  localparam int CH_CNT  = 4;
  localparam int REG_W   = 16;
  localparam int UPD_BIT = 0;
  localparam int CC_LSB  = UPD_BIT + 1;
  localparam int COM_BIT = CC_LSB + CH_CNT;
  localparam int TRG_BIT = COM_BIT + 1;
  localparam int BRK_BIT = TRG_BIT + 1;
  localparam int IRQ_W   = BRK_BIT + 1;
  localparam int OF_LSB  = IRQ_W + 1;

  function automatic logic [REG_W-1:0] buildMask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < IRQ_W; i++) m[i] = 1'b1;
    for (int i = 0; i < CH_CNT; i++) m[OF_LSB + i] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] IMPL_MASK = buildMask();

  typedef struct packed {
    logic [REG_W-1:0] setBits;
    logic [REG_W-1:0] clrBits;
  } strobe_t;
endpackage

// File: rtl/tes_ctl.sv
module tes_ctl
  import tes_pkg::*;
(
  input  logic              selIn,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  input  logic              updEvt,
  input  logic [CH_CNT-1:0] ccEvt,
  input  logic [CH_CNT-1:0] captureMode,
  input  logic [CH_CNT-1:0] ccFlags,
  input  logic              comEvt,
  input  logic              trgEvt,
  input  logic              gatedMode,
  input  logic              brkLevel,
  output strobe_t           strb
);
  logic [REG_W-1:0] setVec;

  always_comb begin
    setVec = '0;
    setVec[UPD_BIT] = updEvt;
    setVec[COM_BIT] = comEvt;
    setVec[TRG_BIT] = trgEvt & ~gatedMode;
    setVec[BRK_BIT] = brkLevel;
    for (int i = 0; i < CH_CNT; i++) begin
      setVec[CC_LSB + i] = ccEvt[i];
      setVec[OF_LSB + i] = ccEvt[i] & captureMode[i] & ccFlags[i];
    end
  end

  assign strb.setBits = setVec & IMPL_MASK;
  assign strb.clrBits = (selIn && wrEn) ? (~wrData & IMPL_MASK) : '0;
endmodule

// File: rtl/tes_flags.sv
module tes_flags
  import tes_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             selIn,
  input  logic [IRQ_W-1:0] irqEnable,
  output logic [REG_W-1:0] flags,
  output logic [REG_W-1:0] rdData,
  output logic             irqOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= ((flags & ~strb.clrBits) | strb.setBits) & IMPL_MASK;
  end

  assign rdData = selIn ? flags : '0;
  assign irqOut = |(flags[IRQ_W-1:0] & irqEnable);
endmodule

// File: rtl/tim_event_status.sv
module tim_event_status
  import tes_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              selIn,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [IRQ_W-1:0]  irqEnable,
  output logic              irqOut,
  input  logic              updEvt,
  input  logic [CH_CNT-1:0] ccEvt,
  input  logic [CH_CNT-1:0] captureMode,
  input  logic              comEvt,
  input  logic              trgEvt,
  input  logic              gatedMode,
  input  logic              brkLevel
);
  strobe_t          strbBus;
  logic [REG_W-1:0] flagBus;

  tes_ctl u_ctl (
    .selIn(selIn), .wrEn(wrEn), .wrData(wrData),
    .updEvt(updEvt), .ccEvt(ccEvt), .captureMode(captureMode),
    .ccFlags(flagBus[CC_LSB +: CH_CNT]),
    .comEvt(comEvt), .trgEvt(trgEvt), .gatedMode(gatedMode),
    .brkLevel(brkLevel), .strb(strbBus)
  );

  tes_flags u_flags (
    .clk(clk), .rstN(rstN), .strb(strbBus), .selIn(selIn),
    .irqEnable(irqEnable), .flags(flagBus), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: rtl/tes_checker.sv
module tes_checker
  import tes_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [REG_W-1:0]  flags,
  input logic              irqOut,
  input logic              selIn,
  input logic              wrEn,
  input logic [REG_W-1:0]  wrData,
  input logic              updEvt,
  input logic [CH_CNT-1:0] ccEvt,
  input logic [CH_CNT-1:0] captureMode,
  input logic              trgEvt,
  input logic              gatedMode,
  input logic              brkLevel
);
  a_r1_reset_clear: assert property (@(posedge clk) !rstN |=> flags == '0);

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (flags & ~IMPL_MASK) == '0);

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    updEvt |=> flags[UPD_BIT]);

  a_r3_write_one_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (selIn && wrEn && wrData[UPD_BIT] && !flags[UPD_BIT] && !updEvt) |=> !flags[UPD_BIT]);

  a_r6_overcapture: assert property (@(posedge clk) disable iff (!rstN)
    (ccEvt[0] && captureMode[0] && flags[CC_LSB]) |=> flags[OF_LSB]);

  a_r6_no_oc_compare: assert property (@(posedge clk) disable iff (!rstN)
    (!flags[OF_LSB] && !captureMode[0]) |=> !flags[OF_LSB]);

  a_r7_break_held: assert property (@(posedge clk) disable iff (!rstN)
    brkLevel |=> flags[BRK_BIT]);

  a_r8_gated_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (trgEvt && gatedMode && !flags[TRG_BIT]) |=> !flags[TRG_BIT]);

  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (flags[IRQ_W-1:0] != '0));
endmodule

bind tim_event_status tes_checker u_chk (
  .clk(clk), .rstN(rstN), .flags(flagBus), .irqOut(irqOut),
  .selIn(selIn), .wrEn(wrEn), .wrData(wrData), .updEvt(updEvt),
  .ccEvt(ccEvt), .captureMode(captureMode), .trgEvt(trgEvt),
  .gatedMode(gatedMode), .brkLevel(brkLevel)
);

// File: tb/sim_tim_event_status.sv
`timescale 1ns/1ps
module sim_tim_event_status;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selIn = 1'b1, wrEn = 1'b0;
  logic [15:0] wrData = 16'h0;
  logic [15:0] rdData;
  logic [7:0]  irqEnable = 8'h0;
  logic        irqOut;
  logic        updEvt = 0, comEvt = 0, trgEvt = 0, gatedMode = 0, brkLevel = 0;
  logic [3:0]  ccEvt = 0, captureMode = 0;

  int checks = 0, fails = 0;
  logic [15:0] expFlags = 16'h0;
  bit done = 0;

  always #2 clk = ~clk;

  tim_event_status u0 (
    .clk(clk), .rstN(rstN), .selIn(selIn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irqEnable(irqEnable), .irqOut(irqOut), .updEvt(updEvt),
    .ccEvt(ccEvt), .captureMode(captureMode), .comEvt(comEvt), .trgEvt(trgEvt),
    .gatedMode(gatedMode), .brkLevel(brkLevel)
  );

  function automatic logic [15:0] modelNext(logic [15:0] cur);
    logic [15:0] s, c;
    s = 16'h0;
    s[0] = updEvt;
    s[5] = comEvt;
    s[6] = trgEvt & ~gatedMode;
    s[7] = brkLevel;
    for (int i = 0; i < 4; i++) begin
      s[1+i] = ccEvt[i];
      s[9+i] = ccEvt[i] & captureMode[i] & cur[1+i];
    end
    c = (selIn && wrEn) ? ~wrData : 16'h0;
    return ((cur & ~c) | s) & 16'h1EFF;
  endfunction

  function automatic logic modelIrq(logic [15:0] f, logic [7:0] en);
    return |(f[7:0] & en);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    expFlags = modelNext(expFlags);
    @(posedge clk);
    @(negedge clk);
    updEvt = 0; comEvt = 0; trgEvt = 0; ccEvt = 0; wrEn = 0;
  endtask

  task automatic writeReg(logic [15:0] d);
    wrEn = 1; wrData = d;
    tick();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual timeout expected finish");
    if (!done) $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", rdData, 16'h0000);
    rstN = 1;
    @(negedge clk);

    updEvt = 1; tick();
    check("R2 update bit0", rdData, 16'h0001);
    writeReg(16'hFFFF);
    check("R3 write one keeps", rdData, 16'h0001);
    writeReg(16'hFFFE);
    check("R3 write zero clears", rdData, 16'h0000);

    updEvt = 1; writeReg(16'h0000);
    check("R5 set beats clear", rdData, 16'h0001);
    writeReg(16'h0000);

    ccEvt = 4'b0100; tick();
    check("R2 cc3 bit3", rdData, 16'h0008);
    ccEvt = 4'b0100; tick();
    check("R6 compare mode no overcapture", rdData, 16'h0008);
    captureMode = 4'b0100; ccEvt = 4'b0100; tick();
    check("R6 overcapture ch3 bit11", rdData, 16'h0808);
    writeReg(16'h0000);
    ccEvt = 4'b0100; tick();
    check("R6 first capture no overcapture", rdData, 16'h0008);
    captureMode = 0;
    writeReg(16'h0000);

    comEvt = 1; tick();
    check("R9 commutation bit5", rdData, 16'h0020);
    writeReg(16'h0000);

    gatedMode = 1; trgEvt = 1; tick();
    check("R8 gated trigger ignored", rdData, 16'h0000);
    gatedMode = 0; trgEvt = 1; tick();
    check("R8 trigger bit6", rdData, 16'h0040);
    writeReg(16'h0000);

    brkLevel = 1; tick();
    check("R7 break set", rdData, 16'h0080);
    writeReg(16'h0000);
    check("R7 clear blocked while active", rdData, 16'h0080);
    brkLevel = 0; tick();
    writeReg(16'h0000);
    check("R7 clear after release", rdData, 16'h0000);

    writeReg(16'hFFFF);
    check("R4 reserved bits read zero", rdData, 16'h0000);

    captureMode = 4'b0001; ccEvt = 4'b0001; tick();
    ccEvt = 4'b0001; tick();
    writeReg(16'hFFFD);
    irqEnable = 8'hFF;
    @(negedge clk);
    check("R10 overcapture alone no irq", {15'h0, irqOut}, 16'h0000);
    check("R10 flag state", rdData, 16'h0200);
    writeReg(16'h0000);
    captureMode = 0;
    comEvt = 1; irqEnable = 8'hDF; tick();
    check("R10 disabled flag no irq", {15'h0, irqOut}, 16'h0000);
    irqEnable = 8'h20;
    @(negedge clk);
    check("R10 enabled flag irq", {15'h0, irqOut}, 16'h0001);
    selIn = 0;
    @(negedge clk);
    check("R11 unselected reads zero", rdData, 16'h0000);
    selIn = 1;

    void'($urandom(32'h5EED));
    for (int n = 0; n < 4000; n++) begin
      updEvt = ($urandom % 8) == 0;
      comEvt = ($urandom % 10) == 0;
      trgEvt = ($urandom % 6) == 0;
      gatedMode = ($urandom % 3) == 0;
      brkLevel = ($urandom % 12) == 0;
      ccEvt = 4'($urandom) & 4'($urandom);
      captureMode = 4'($urandom);
      irqEnable = 8'($urandom);
      wrEn = ($urandom % 4) == 0;
      wrData = 16'($urandom) | 16'($urandom);
      expFlags = modelNext(expFlags);
      @(posedge clk);
      @(negedge clk);
      check("R3 R5 random flags", rdData, expFlags);
      check("R10 random irq", {15'h0, irqOut}, {15'h0, modelIrq(expFlags, irqEnable)});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule